// File: doc/BRIEF.md
# Partitioned SIMD Adder/Subtractor

This unit adds, subtracts or decrements two 16-bit operands. The carry chain can be cut at the nibble boundaries at run time. With one configuration word the same hardware acts as one 16-bit adder, two independent 8-bit adders or four independent 4-bit adders. Each lane takes its own carry-in and gives its own carry-out. Both sit in 4-bit vectors, at the index of the lane's lowest nibble.

The unit is purely combinational. It sits in a datapath stage that already holds its operands in registers. The subtract operation adds the inverted B operand. A true two's-complement difference therefore needs the lane's carry-in set to 1. The third operation adds an all-ones B with no carry-in. In each lane this gives A minus one, and the carry-out is set whenever the lane's A is nonzero.

Top module: `psa_top`

## Requirements
- R1: With op_i = 00 (add), each lane's result is (A_lane + B_lane + carry-in) truncated to the lane width.
- R2: With op_i = 01 (subtract), each lane's result is (A_lane + ~B_lane + carry-in) truncated to the lane width. With carry-in 1 this is A_lane - B_lane.
- R3: With op_i = 10, each lane's result is A_lane plus an all-ones value, with the carry-in forced to 0. The cin_i bits have no effect on sum_o or cout_o in this mode.
- R4: part_i bit k (k = 0..2) cuts the carry chain between nibble k (bits 4k+3..4k) and nibble k+1. Code 000 gives one 16-bit lane, 010 gives two 8-bit lanes and 111 gives four 4-bit lanes. Every other code cuts at each of its set bits independently, for example 001 gives a 4-bit lane below a 12-bit lane.
- R5: Across a boundary whose part_i bit is clear, the carry out of the lower nibble propagates into the upper nibble.
- R6: cin_i bit i is used only when nibble i is the lowest nibble of a lane. Nibble 0 is always the lowest nibble of a lane. All other cin_i bits have no effect.
- R7: cout_o bit i is set when nibble i is the lowest nibble of a lane and that lane's untruncated sum does not fit in the lane's width.
- R8: cout_o bits for nibbles that are not the lowest nibble of a lane are 0.
- R9: op_i = 11 behaves exactly like add.
- R10: The outputs depend only on the current inputs. No clock or state is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| cin_i | input | 4 | Per-lane carry-in, indexed by the lane's lowest nibble |
| op_i | input | 2 | 00 add, 01 subtract, 10 add all-ones, 11 add |
| part_i | input | 3 | Lane cut bits for the boundaries above nibbles 0, 1, 2 |
| sum_o | output | 16 | Lane-wise result |
| cout_o | output | 4 | Per-lane carry-out, indexed by the lane's lowest nibble |

## Verification
There is no stored state, so every fault appears in the same evaluation as the inputs that expose it. A boundary that is wrongly cut or wrongly joined shows as a nibble that is off by one, but only for operands that generate a carry across that boundary. For this reason the vectors include all-ones and carry-rippling values. A carry-in that is steered to the wrong place shows when cin_i differs between nibbles. A misplaced carry-out shows as a set bit at an index that is not the lowest nibble of a lane. Every configuration is compared against a lane-by-lane model that the bench computes from the requirements.

// File: rtl/psa_pkg.sv
// Shared definitions for the partitioned adder/subtractor.
// Assumes operand width is a whole number of nibbles.
package psa_pkg;
    localparam int unsigned NIB_W = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_DEC = 2'b10,
        OP_ALT = 2'b11
    } psa_op_e;
endpackage

// File: rtl/psa_lane_map.sv
// Decodes the cut bits into per-nibble lane-start and lane-top flags.
// Assumes nibble 0 always begins a lane and the last nibble always ends one.
module psa_lane_map #(
    parameter int unsigned NUM_NIB = 4
) (
    input  logic [NUM_NIB-2:0] part_i,
    output logic [NUM_NIB-1:0] start_o,
    output logic [NUM_NIB-1:0] top_o
);
    // lane starts: nibble 0 plus every nibble above a set cut bit
    assign start_o = {part_i, 1'b1};

    // lane tops: last nibble plus every nibble below a set cut bit
    assign top_o = {1'b1, part_i};

    // each lane has exactly one start and one top
    always_comb begin
        AST_LANE_BALANCE: assert ($countones(start_o) == $countones(top_o))
            else $error("lane start/top count differ"); // R4
    end
endmodule

// File: rtl/psa_operand.sv
// Forms the effective B operand and carry-in vector for the chosen operation.
// Assumes the unknown code 11 is handled as add.
module psa_operand
    import psa_pkg::*;
#(
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned NUM_NIB = 4
) (
    input  psa_op_e            op_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [NUM_NIB-1:0] cin_i,
    output logic [WIDTH-1:0]   b_eff_o,
    output logic [NUM_NIB-1:0] cin_eff_o
);
    // select B as-is, inverted, or all ones; drop carry-ins for the all-ones mode
    always_comb begin
        b_eff_o   = b_i;
        cin_eff_o = cin_i;
        unique case (op_i)
            OP_SUB: b_eff_o = ~b_i;
            OP_DEC: begin
                b_eff_o   = '1;
                cin_eff_o = '0;
            end
            default: b_eff_o = b_i;
        endcase
    end
endmodule

// File: rtl/psa_nibble_chain.sv
// Nibble-sliced ripple adder with a carry-select at every boundary and
// per-lane carry-out gathering. Assumes start/top flags are consistent.
module psa_nibble_chain
    import psa_pkg::*;
#(
    parameter int unsigned NUM_NIB = 4,
    localparam int unsigned WIDTH  = NUM_NIB * NIB_W
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [NUM_NIB-1:0] cin_i,
    input  logic [NUM_NIB-1:0] start_i,
    input  logic [NUM_NIB-1:0] top_i,
    output logic [WIDTH-1:0]   sum_o,
    output logic [NUM_NIB-1:0] cout_o
);
    logic [NUM_NIB-1:0] c_in;
    logic [NUM_NIB-1:0] c_out;
    logic [NUM_NIB-1:0] lane_co;

    for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
        // carry source: external at a lane start, ripple otherwise
        if (i == 0) begin : g_first
            assign c_in[i] = cin_i[i];
        end else begin : g_rest
            assign c_in[i] = start_i[i] ? cin_i[i] : c_out[i-1];
        end

        // nibble add with carry
        assign {c_out[i], sum_o[i*NIB_W +: NIB_W]} =
            {1'b0, a_i[i*NIB_W +: NIB_W]} + {1'b0, b_i[i*NIB_W +: NIB_W]}
            + {{NIB_W{1'b0}}, c_in[i]};
    end

    // walk downward so each nibble sees the carry-out of its lane's top nibble
    for (genvar i = 0; i < NUM_NIB; i++) begin : g_gather
        if (i == NUM_NIB - 1) begin : g_last
            assign lane_co[i] = c_out[i];
        end else begin : g_mid
            assign lane_co[i] = top_i[i] ? c_out[i] : lane_co[i+1];
        end
        // report only at the lane's lowest nibble
        assign cout_o[i] = start_i[i] & lane_co[i];
    end

    // a joined boundary must hand the lower carry through unchanged
    always_comb begin
        for (int i = 1; i < NUM_NIB; i++) begin
            if (!start_i[i]) begin
                AST_RIPPLE_PASS: assert (c_in[i] == c_out[i-1])
                    else $error("ripple broken at nibble %0d", i); // R5
            end
        end
    end
endmodule

// File: rtl/psa_top.sv
// Partitioned 16-bit add/subtract/decrement unit with per-lane carries.
// Purely combinational; assumes registered inputs upstream.
module psa_top
    import psa_pkg::*;
#(
    parameter int unsigned NUM_NIB = 4,
    localparam int unsigned WIDTH  = NUM_NIB * NIB_W
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [NUM_NIB-1:0] cin_i,
    input  logic [1:0]         op_i,
    input  logic [NUM_NIB-2:0] part_i,
    output logic [WIDTH-1:0]   sum_o,
    output logic [NUM_NIB-1:0] cout_o
);
    logic [NUM_NIB-1:0] start;
    logic [NUM_NIB-1:0] top;
    logic [WIDTH-1:0]   b_eff;
    logic [NUM_NIB-1:0] cin_eff;
    psa_op_e            op;

    assign op = psa_op_e'(op_i);

    psa_lane_map #(.NUM_NIB(NUM_NIB)) i_map (
        .part_i (part_i),
        .start_o(start),
        .top_o  (top)
    );

    psa_operand #(.WIDTH(WIDTH), .NUM_NIB(NUM_NIB)) i_opnd (
        .op_i     (op),
        .b_i      (b_i),
        .cin_i    (cin_i),
        .b_eff_o  (b_eff),
        .cin_eff_o(cin_eff)
    );

    psa_nibble_chain #(.NUM_NIB(NUM_NIB)) i_chain (
        .a_i    (a_i),
        .b_i    (b_eff),
        .cin_i  (cin_eff),
        .start_i(start),
        .top_i  (top),
        .sum_o  (sum_o),
        .cout_o (cout_o)
    );

    // whole-word cross-checks against plain arithmetic in the unsplit mode
    always_comb begin
        AST_COUT_AT_START: assert ((cout_o & ~start) == '0)
            else $error("carry-out outside lane start"); // R8
        if (part_i == '0 && (op_i == 2'b00 || op_i == 2'b11)) begin
            AST_FULL_ADD: assert ({cout_o[0], sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i[0]}))
                else $error("full-width add mismatch"); // R1
        end
        if (part_i == '0 && op_i == 2'b01) begin
            AST_FULL_SUB: assert ({cout_o[0], sum_o} ==
                ({1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, cin_i[0]}))
                else $error("full-width subtract mismatch"); // R2
        end
        if (part_i == '0 && op_i == 2'b10) begin
            AST_FULL_DEC: assert ({cout_o[0], sum_o} ==
                ({1'b0, a_i} + {1'b0, {WIDTH{1'b1}}}))
                else $error("full-width all-ones add mismatch"); // R3
        end
    end
endmodule

// File: tb/test_psa_top.sv
// Directed bench for psa_top; a lane-wise model computes expected values.
module test_psa_top;
    logic        clk = 1'b0;
    logic [15:0] a, b, sum;
    logic [3:0]  cin, cout;
    logic [1:0]  op;
    logic [2:0]  part;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    psa_top i_psa_top (
        .a_i(a), .b_i(b), .cin_i(cin), .op_i(op), .part_i(part),
        .sum_o(sum), .cout_o(cout)
    );

    // lane-wise reference built from the requirements
    task automatic model(input logic [15:0] ma, mb, input logic [3:0] mc,
                         input logic [1:0] mo, input logic [2:0] mp,
                         output logic [15:0] es, output logic [3:0] ec);
        logic [3:0]  cuts;
        logic [15:0] bb;
        logic [3:0]  cc;
        cuts = {mp, 1'b1};
        bb = (mo == 2'b01) ? ~mb : (mo == 2'b10) ? 16'hFFFF : mb;
        cc = (mo == 2'b10) ? 4'b0 : mc;
        es = '0;
        ec = '0;
        for (int s = 0; s < 4; s++) begin
            if (cuts[s]) begin
                int e;
                int w;
                logic [16:0] la, lb, ls, msk;
                e = s + 1;
                while (e < 4 && !cuts[e]) e++;
                w = 4 * (e - s);
                msk = (17'd1 << w) - 17'd1;
                la = ({1'b0, ma} >> (4 * s)) & msk;
                lb = ({1'b0, bb} >> (4 * s)) & msk;
                ls = la + lb + {16'b0, cc[s]};
                es = es | 16'((ls & msk) << (4 * s));
                ec[s] = ls[w];
            end
        end
    endtask

    task automatic apply_check(input string tag, input logic [15:0] ta, tb,
                               input logic [3:0] tc, input logic [1:0] to,
                               input logic [2:0] tp);
        logic [15:0] es;
        logic [3:0]  ec;
        @(negedge clk);
        a = ta; b = tb; cin = tc; op = to; part = tp;
        #2;
        model(ta, tb, tc, to, tp, es, ec);
        n_cmp++;
        if (sum !== es || cout !== ec) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h cin=%b op=%b part=%b sum=%h cout=%b expected sum=%h cout=%b",
                     tag, ta, tb, tc, to, tp, sum, cout, es, ec);
        end
    endtask

    task automatic t_reset_state;  // all-zero inputs give zero outputs (R10)
        apply_check("R10 zero", 16'h0, 16'h0, 4'h0, 2'b00, 3'b000);
    endtask

    task automatic t_add_split;  // R1 R4 R5 R7 in three splits
        logic [15:0] va [5] = '{16'h0000, 16'h1234, 16'hFFFF, 16'hABCD, 16'h0FF8};
        logic [15:0] vb [5] = '{16'h0000, 16'h1234, 16'h0001, 16'hABCD, 16'h0008};
        for (int i = 0; i < 5; i++) begin
            apply_check("R1 add 1x16", va[i], vb[i], 4'b0000, 2'b00, 3'b000);
            apply_check("R5 add 1x16 cin", va[i], vb[i], 4'b0001, 2'b00, 3'b000);
            apply_check("R4 add 2x8", va[i], vb[i], 4'b0101, 2'b00, 3'b010);
            apply_check("R7 add 4x4", va[i], vb[i], 4'b1111, 2'b00, 3'b111);
        end
    endtask

    task automatic t_sub;  // R2 true difference and raw complement add
        apply_check("R2 sub eq", 16'h1234, 16'h1234, 4'b0001, 2'b01, 3'b000);
        apply_check("R2 sub borrow", 16'h0000, 16'hFFFF, 4'b0001, 2'b01, 3'b000);
        apply_check("R2 sub 2x8", 16'h8000, 16'h0001, 4'b0101, 2'b01, 3'b010);
        apply_check("R2 sub 4x4 nocin", 16'hBEEF, 16'hFEED, 4'b0000, 2'b01, 3'b111);
        apply_check("R2 sub 4x4", 16'hABCD, 16'hABCE, 4'b1111, 2'b01, 3'b111);
    endtask

    task automatic t_dec;  // R3 carry-ins ignored, A plus all ones
        apply_check("R3 dec zero", 16'h0000, 16'h1234, 4'b1111, 2'b10, 3'b000);
        apply_check("R3 dec 2x8", 16'h0100, 16'h0, 4'b0101, 2'b10, 3'b010);
        apply_check("R3 dec 4x4", 16'h1020, 16'hFFFF, 4'b1111, 2'b10, 3'b111);
        apply_check("R3 dec 4x4 nocin", 16'h1020, 16'hFFFF, 4'b0000, 2'b10, 3'b111);
    endtask

    task automatic t_cin_ignored;  // R6 cin on non-start nibbles has no effect
        apply_check("R6 ignore 1x16", 16'h0FFF, 16'h0000, 4'b1110, 2'b00, 3'b000);
        apply_check("R6 ignore 2x8", 16'h00FF, 16'h00FF, 4'b1010, 2'b00, 3'b010);
        apply_check("R6 used 2x8", 16'h00FF, 16'h00FF, 4'b0100, 2'b00, 3'b010);
    endtask

    task automatic t_cout_zero;  // R8 overflowing lanes report only at start
        apply_check("R8 1x16", 16'hFFFF, 16'hFFFF, 4'b0001, 2'b00, 3'b000);
        apply_check("R8 2x8", 16'hFFFF, 16'hFFFF, 4'b0101, 2'b00, 3'b010);
    endtask

    task automatic t_alt_op;  // R9 code 11 equals add
        apply_check("R9 alt 4x4", 16'h9A7F, 16'h7C81, 4'b1011, 2'b11, 3'b111);
        apply_check("R9 alt 1x16", 16'hFFFF, 16'h0001, 4'b0000, 2'b11, 3'b000);
    endtask

    task automatic t_odd_cfg;  // R4 uneven splits cut independently
        apply_check("R4 4+12", 16'hFFFF, 16'h0011, 4'b0000, 2'b00, 3'b001);
        apply_check("R4 12+4", 16'hFFFF, 16'h1001, 4'b1000, 2'b00, 3'b100);
        apply_check("R4 4+4+8", 16'hF0FF, 16'h1111, 4'b0011, 2'b01, 3'b011);
        apply_check("R4 8+4+4 dec", 16'h0100, 16'h0, 4'b1111, 2'b10, 3'b110);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        a = '0; b = '0; cin = '0; op = '0; part = '0;
        t_reset_state();
        t_add_split();
        t_sub();
        t_dec();
        t_cin_ignored();
        t_cout_zero();
        t_alt_op();
        t_odd_cfg();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end
endmodule